// File: doc/BRIEF.md
# Channel Direction and Window Detect Control

This block decides, for each of 32 adapter channels, whether the driver toward the device under test is on and whether the return driver back toward the pattern host is on. The channels are handled in groups of four (nibbles). Each nibble has a mode set by configuration registers: fixed driver, fixed receiver or bidirectional. A bidirectional nibble takes its direction, cycle by cycle, from one of four direction-control inputs. These inputs are the host data of channels 28 to 31, which are dedicated to this job whenever bidirectional groups are in use.

Each nibble can also enable window detection. Every channel supplies two comparator results: above the low threshold and above the high threshold. When detection is on and a level sits above the low threshold but not above the high threshold, the block switches the return driver off. The far end then sees an undriven line and can flag the level as indeterminate. All outputs are registered. A configuration write reaches the outputs two clock edges after it is presented. A change on a control or comparator input reaches them one edge later.

Top module: `chan_dir_ctl`

## Requirements
- R1: After reset every stored configuration byte reads back as 0x00, every device driver enable (drv_en) is 0 and every return enable (ret_en) is 1, so all channels start as receivers with detection off.
- R2: A write stores wr_data at wr_addr. Register 0 holds the mode bits of nibbles 0..3, register 1 the mode bits of nibbles 4..7, register 2 the detection bits of nibbles 0..3 and register 3 those of nibbles 4..7. rd_data shows the byte at rd_addr one clock after rd_addr is presented.
- R3: In mode register r, bit 4+k is the bidirectional bit and bit k is the fixed-driver bit of nibble 4r+k.
- R4: A fixed-driver nibble (bidirectional bit 0, fixed-driver bit 1) has drv_en=1 and ret_en=0 on all four channels.
- R5: A nibble with both mode bits 0 is a fixed receiver: drv_en=0 and ret_en=1, unless R9 applies.
- R6: A bidirectional nibble k (k<7) follows dir_ctl[k/2]. Index 0 stands for channel 28 and covers channels 0..7, and index 3 stands for channel 31 and covers only channels 24..27. A 1 gives drv_en=1 and ret_en=0. A 0 gives drv_en=0 and ret_en=1.
- R7: Nibble 7 (channels 28..31) is never bidirectional: its bidirectional bit has no effect on the outputs.
- R8: While any of nibbles 0..6 is bidirectional, nibble 7 acts as a fixed driver whatever its own mode bits hold.
- R9: In detection register r, bit k enables window detection for nibble 4r+k. When it is set, a channel with above_lo=1 and above_hi=0 has ret_en=0.
- R10: Any other comparator pair leaves ret_en unchanged, and bits 7..4 of the detection registers are stored but have no effect.
- R11: drv_en and ret_en are registered. They reflect dir_ctl, above_lo and above_hi as sampled at the previous clock edge, and reflect a configuration write one edge after the write is stored.
- R12: A nibble with both its bidirectional and fixed-driver bits set is bidirectional.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register written |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 2 | Configuration register read back |
| rd_data | output | 8 | Registered readback byte |
| dir_ctl | input | 4 | Direction controls (channels 28..31 host data) |
| above_lo | input | 32 | Per-channel comparator: level above low threshold |
| above_hi | input | 32 | Per-channel comparator: level above high threshold |
| drv_en | output | 32 | Per-channel enable of the driver toward the device |
| ret_en | output | 32 | Per-channel enable of the return driver toward the host |

## Verification
On a bidirectional channel, a direction flip and a window hit can land in the same cycle, and both act on ret_en. The bench sets several nibbles bidirectional with detection enabled. In the same cycle it toggles dir_ctl and presents above_lo=1, above_hi=0 on some channels of those nibbles. It then requires ret_en to be low on every channel that is either driving or in the window, and high only where the group receives and the level lies outside the window. A configuration write that lands in the same cycle as an input change is judged the same way. The scoreboard expects old-configuration results for one cycle and new-configuration results after that.

// File: rtl/chdir_pkg.sv
package chdir_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    MODE_RECV  = 2'd0,
    MODE_DRIVE = 2'd1,
    MODE_BIDIR = 2'd2
  } nib_mode_e;
endpackage

// File: rtl/chdir_regs.sv
module chdir_regs #(
  parameter int N_NIB  = 8,
  parameter int DATA_W = 8,
  localparam int NPR    = DATA_W / 2,
  localparam int N_REG  = N_NIB / NPR,
  localparam int ADDR_W = $clog2(2 * N_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_NIB-1:0]  bidir_bits,
  output logic [N_NIB-1:0]  fix_bits,
  output logic [N_NIB-1:0]  win_bits
);
  // Mode registers at 0..N_REG-1, detection registers after them.
  logic [DATA_W-1:0] cfg_q [2*N_REG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2 * N_REG; i++) cfg_q[i] <= '0;
    end else if (wr_en) begin
      cfg_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= cfg_q[rd_addr];
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_fields
    assign fix_bits[r*NPR +: NPR]   = cfg_q[r][NPR-1:0];
    assign bidir_bits[r*NPR +: NPR] = cfg_q[r][DATA_W-1:NPR];
    assign win_bits[r*NPR +: NPR]   = cfg_q[N_REG+r][NPR-1:0];
  end
endmodule

// File: rtl/chdir_mode.sv
module chdir_mode #(
  parameter int N_NIB = 8
) (
  input  logic [N_NIB-1:0] bidir_bits,
  input  logic [N_NIB-1:0] fix_bits,
  output logic [N_NIB-1:0] is_bidir,
  output logic [N_NIB-1:0] is_drive
);
  logic any_bidir;

  // The last nibble carries the direction controls, so only the others count.
  assign any_bidir = |bidir_bits[N_NIB-2:0];

  for (genvar n = 0; n < N_NIB; n++) begin : g_nib
    if (n == N_NIB - 1) begin : g_ctl_nib
      assign is_bidir[n] = 1'b0;
      assign is_drive[n] = fix_bits[n] | any_bidir;
    end else begin : g_data_nib
      assign is_bidir[n] = bidir_bits[n];
      assign is_drive[n] = fix_bits[n] & ~bidir_bits[n];
    end
  end
endmodule

// File: rtl/chdir_lane.sv
module chdir_lane
  import chdir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             is_bidir,
  input  logic             is_drive,
  input  logic             dir_ctl,
  input  logic             win_en,
  input  logic [NIB_W-1:0] above_lo,
  input  logic [NIB_W-1:0] above_hi,
  output logic [NIB_W-1:0] drv_en,
  output logic [NIB_W-1:0] ret_en
);
  nib_mode_e        mode;
  logic [NIB_W-1:0] drv_d;
  logic [NIB_W-1:0] ret_base;
  logic [NIB_W-1:0] hole;

  always_comb begin
    if (is_bidir)      mode = MODE_BIDIR;
    else if (is_drive) mode = MODE_DRIVE;
    else               mode = MODE_RECV;
  end

  always_comb begin
    unique case (mode)
      MODE_BIDIR: begin
        drv_d    = {NIB_W{dir_ctl}};
        ret_base = {NIB_W{~dir_ctl}};
      end
      MODE_DRIVE: begin
        drv_d    = '1;
        ret_base = '0;
      end
      default: begin
        drv_d    = '0;
        ret_base = '1;
      end
    endcase
  end

  assign hole = {NIB_W{win_en}} & above_lo & ~above_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en <= '0;
      ret_en <= '1;
    end else begin
      drv_en <= drv_d;
      ret_en <= ret_base & ~hole;
    end
  end
endmodule

// File: rtl/chan_dir_ctl.sv
module chan_dir_ctl
  import chdir_pkg::*;
#(
  parameter int N_NIB   = 8,
  parameter int DATA_W  = 8,
  parameter int GRP_NIB = 2,
  localparam int N_CH   = N_NIB * NIB_W,
  localparam int N_CTL  = (N_NIB - 1 + GRP_NIB - 1) / GRP_NIB,
  localparam int NPR    = DATA_W / 2,
  localparam int N_REG  = N_NIB / NPR,
  localparam int ADDR_W = $clog2(2 * N_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_CTL-1:0]  dir_ctl,
  input  logic [N_CH-1:0]   above_lo,
  input  logic [N_CH-1:0]   above_hi,
  output logic [N_CH-1:0]   drv_en,
  output logic [N_CH-1:0]   ret_en
);
  logic [N_NIB-1:0] bidir_bits;
  logic [N_NIB-1:0] fix_bits;
  logic [N_NIB-1:0] win_bits;
  logic [N_NIB-1:0] is_bidir;
  logic [N_NIB-1:0] is_drive;

  chdir_regs #(.N_NIB(N_NIB), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .bidir_bits (bidir_bits),
    .fix_bits   (fix_bits),
    .win_bits   (win_bits)
  );

  chdir_mode #(.N_NIB(N_NIB)) u_mode (
    .bidir_bits (bidir_bits),
    .fix_bits   (fix_bits),
    .is_bidir   (is_bidir),
    .is_drive   (is_drive)
  );

  for (genvar n = 0; n < N_NIB; n++) begin : g_lane
    localparam int CI = (n / GRP_NIB < N_CTL) ? n / GRP_NIB : N_CTL - 1;
    chdir_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .is_bidir (is_bidir[n]),
      .is_drive (is_drive[n]),
      .dir_ctl  (dir_ctl[CI]),
      .win_en   (win_bits[n]),
      .above_lo (above_lo[n*NIB_W +: NIB_W]),
      .above_hi (above_hi[n*NIB_W +: NIB_W]),
      .drv_en   (drv_en[n*NIB_W +: NIB_W]),
      .ret_en   (ret_en[n*NIB_W +: NIB_W])
    );
  end
endmodule

// File: rtl/chan_dir_ctl_chk.sv
module chan_dir_ctl_chk
  import chdir_pkg::*;
#(
  parameter int N_NIB = 8,
  localparam int N_CH = N_NIB * NIB_W
) (
  input logic             clk,
  input logic             rst,
  input logic [N_CH-1:0]  above_lo,
  input logic [N_CH-1:0]  above_hi,
  input logic [N_CH-1:0]  drv_en,
  input logic [N_CH-1:0]  ret_en,
  input logic [N_NIB-1:0] bidir_bits,
  input logic [N_NIB-1:0] fix_bits,
  input logic [N_NIB-1:0] win_bits
);
  logic [N_CH-1:0] drv_want;
  logic [N_CH-1:0] rcv_want;
  logic [N_CH-1:0] hole_want;
  logic            any_b;

  assign any_b = |bidir_bits[N_NIB-2:0];

  always_comb begin
    drv_want  = '0;
    rcv_want  = '0;
    hole_want = '0;
    for (int n = 0; n < N_NIB; n++) begin
      hole_want[n*NIB_W +: NIB_W] = {NIB_W{win_bits[n]}} &
        above_lo[n*NIB_W +: NIB_W] & ~above_hi[n*NIB_W +: NIB_W];
      if (n < N_NIB - 1) begin
        drv_want[n*NIB_W +: NIB_W] = {NIB_W{~bidir_bits[n] & fix_bits[n]}};
        rcv_want[n*NIB_W +: NIB_W] = {NIB_W{~bidir_bits[n] & ~fix_bits[n]}};
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (drv_en == '0 && ret_en == '1));

  a_r4_fixed_drive: assert property (@(posedge clk) disable iff (rst)
    ((~drv_en | ret_en) & $past(drv_want)) == '0);

  a_r5_fixed_recv: assert property (@(posedge clk) disable iff (rst)
    (drv_en & $past(rcv_want)) == '0);

  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    (drv_en & ret_en) == '0);

  a_r8_last_forced: assert property (@(posedge clk) disable iff (rst)
    $past(any_b) |-> (drv_en[N_CH-1 -: NIB_W] == '1 && ret_en[N_CH-1 -: NIB_W] == '0));

  a_r9_window_hole: assert property (@(posedge clk) disable iff (rst)
    (ret_en & $past(hole_want)) == '0);
endmodule

bind chan_dir_ctl chan_dir_ctl_chk #(.N_NIB(N_NIB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .above_lo   (above_lo),
  .above_hi   (above_hi),
  .drv_en     (drv_en),
  .ret_en     (ret_en),
  .bidir_bits (bidir_bits),
  .fix_bits   (fix_bits),
  .win_bits   (win_bits)
);

// File: tb/sim_chan_dir_ctl.sv
module sim_chan_dir_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [3:0]  dir_ctl = '0;
  logic [31:0] above_lo = '0;
  logic [31:0] above_hi = '0;
  logic [31:0] drv_en;
  logic [31:0] ret_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] mdl [4];

  typedef struct {
    int          due;
    logic [31:0] d;
    logic [31:0] r;
    string       tag;
  } exp_t;
  exp_t q[$];

  chan_dir_ctl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dir_ctl(dir_ctl),
    .above_lo(above_lo), .above_hi(above_hi), .drv_en(drv_en), .ret_en(ret_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected outputs computed from the requirement text.
  task automatic model(input logic [3:0] c, input logic [31:0] lo, input logic [31:0] hi,
                       output logic [31:0] d, output logic [31:0] r);
    logic anyb;
    anyb = 1'b0;
    for (int n = 0; n < 7; n++) if (mdl[n/4][4 + n%4]) anyb = 1'b1;
    for (int n = 0; n < 8; n++) begin
      logic b, f, w, dd, rr;
      b = mdl[n/4][4 + n%4];
      f = mdl[n/4][n%4];
      w = mdl[2 + n/4][n%4];
      if (n == 7) begin b = 1'b0; f = f | anyb; end
      if (b)      begin dd = c[n/2]; rr = ~c[n/2]; end
      else if (f) begin dd = 1'b1;   rr = 1'b0;    end
      else        begin dd = 1'b0;   rr = 1'b1;    end
      for (int k = 0; k < 4; k++) begin
        int ch;
        ch = n*4 + k;
        d[ch] = dd;
        r[ch] = rr & ~(w & lo[ch] & ~hi[ch]);
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[a] = v;
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] lo, input logic [31:0] hi,
                       input string tag);
    exp_t e;
    @(negedge clk);
    dir_ctl = c; above_lo = lo; above_hi = hi;
    model(c, lo, hi, e.d, e.r);
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [7:0] v, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    total++;
    if (rd_data !== v) begin
      bad++;
      $display("FAIL %s rd_data addr %0d: got %02h exp %02h", tag, a, rd_data, v);
    end
  endtask

  // Monitor: compares each queued item once its cycle has come.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (drv_en !== e.d || ret_en !== e.r) begin
          bad++;
          $display("FAIL %s: drv=%08h ret=%08h exp drv=%08h ret=%08h",
                   e.tag, drv_en, ret_en, e.d, e.r);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired R11");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    total++;
    if (drv_en !== 32'h0 || ret_en !== 32'hFFFF_FFFF) begin
      bad++;
      $display("FAIL R1 reset: drv=%08h ret=%08h exp drv=00000000 ret=ffffffff", drv_en, ret_en);
    end
    for (int a = 0; a < 4; a++) rdchk(a[1:0], 8'h00, "R1");
    apply(4'h0, 32'h0, 32'h0, "R5 default receivers");

    // R2: readback of every register
    wr(2'd0, 8'hA5); rdchk(2'd0, 8'hA5, "R2");
    wr(2'd3, 8'h3C); rdchk(2'd3, 8'h3C, "R2");
    wr(2'd0, 8'h00); wr(2'd3, 8'h00);

    // R3/R4: all fixed drivers, then a mixed layout
    wr(2'd0, 8'h0F); wr(2'd1, 8'h0F);
    apply(4'h0, 32'h0, 32'h0, "R4 all fixed drive");
    wr(2'd0, 8'h05); wr(2'd1, 8'h0A);
    apply(4'h0, 32'h0, 32'h0, "R3 mixed layout");
    apply(4'hF, 32'hFFFF_FFFF, 32'h0, "R5 detection off");

    // R7: nibble 7 bidirectional bit alone has no effect
    wr(2'd0, 8'h00); wr(2'd1, 8'h80);
    apply(4'hF, 32'h0, 32'h0, "R7 nibble7 bidir ignored");
    wr(2'd1, 8'h88);
    apply(4'h0, 32'h0, 32'h0, "R7 nibble7 fixed drive");

    // R6/R8: bidirectional groups, control mapping, forced last nibble
    wr(2'd0, 8'hF0); wr(2'd1, 8'h70);
    apply(4'h0, 32'h0, 32'h0, "R6 ctl 0000");
    apply(4'hF, 32'h0, 32'h0, "R6 ctl 1111");
    apply(4'h5, 32'h0, 32'h0, "R6 ctl 0101");
    apply(4'hA, 32'h0, 32'h0, "R8 ctl 1010");
    wr(2'd0, 8'h00); wr(2'd1, 8'h40);
    apply(4'h8, 32'h0, 32'h0, "R6 ctl31 covers 24..27");
    apply(4'h7, 32'h0, 32'h0, "R8 forced with only nibble6");

    // R12: both bits set means bidirectional
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    apply(4'h2, 32'h0, 32'h0, "R12 bidir over fixed");

    // R9/R10: window detection on receivers
    wr(2'd0, 8'h00); wr(2'd2, 8'h0F); wr(2'd3, 8'h0F);
    apply(4'h0, 32'hFFFF_FFFF, 32'h0, "R9 all in window");
    apply(4'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 above high");
    apply(4'h0, 32'h0, 32'h0, "R10 below low");
    apply(4'h0, 32'h0, 32'hFFFF_FFFF, "R10 odd pair");
    apply(4'h0, 32'h1234_5678, 32'h0F0F_0F0F, "R9 mixed pattern");
    wr(2'd2, 8'hF5); wr(2'd3, 8'hF0);
    apply(4'h0, 32'hFFFF_FFFF, 32'h0, "R10 upper detect bits inert");

    // Same-cycle direction flip and window hit, R6 with R9
    wr(2'd0, 8'hF0); wr(2'd1, 8'h30); wr(2'd2, 8'h0F); wr(2'd3, 8'h0F);
    apply(4'h5, 32'hA5A5_A5A5, 32'h0F00_F00F, "R9 with R6 flip");
    apply(4'hA, 32'h5A5A_5A5A, 32'h00FF_0000, "R9 with R6 flip back");

    // R11: input change one edge later, config write lands mid-stream
    apply(4'h3, 32'h0, 32'h0, "R11 step a");
    apply(4'hC, 32'h0, 32'h0, "R11 step b");
    wr(2'd0, 8'h0F);
    apply(4'hC, 32'hFFFF_FFFF, 32'h0, "R11 after write");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule